// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire, Block Mode)

This block is the serial configuration port of a clock generator. It sits on a two-wire bus (SCL driven by the master, SDA open drain) and holds nine configuration bytes. These bytes select frequencies, enable outputs, apply a signed fine-step offset and carry identification values. The bus lines are brought into a fast system clock through synchronizers. The block detects START and STOP, shifts bytes most-significant bit first, and pulls SDA low to acknowledge.

The transfer framing is block style, and there is no register pointer. A write carries the slave address, then a command byte and a count byte, then data. The command and count bytes are acknowledged and dropped. The data bytes land in register 0, 1, 2 and so on. A read returns a fixed count byte first, then the registers in ascending order. Register 5 mixes writable enables with strap values captured at reset. Registers 6 and 8 are fixed identification values. All nine bytes, as a read would see them, are presented in parallel for the rest of the chip.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), which carry the 7-bit address 1101001. Any other address byte gets no acknowledge, and the bytes that follow it are ignored until the next START.
- R2: In a write, the two bytes after the address are acknowledged and discarded. Each later byte is stored into register 0, 1, 2 and onward in that order.
- R3: In a read, the first byte sent is the count value 0x09. It is followed by registers 0, 1, 2 and onward, each sent MSB first.
- R4: After reset, the registers read 0x42, 0xFF, 0xFF, 0xFF, 0xFF, then register 5 as given by R5, then 0x03, 0x00, 0x02. The parallel output holds register k in bits [8k+7:8k].
- R5: Register 5 reads the inverted reset-time strap FS[3:0] in bits 7..4 and the inverted strap SEL in bit 2, with bit 3 always 1. Only bits 1..0 are writable, and both reset to 1.
- R6: Register 6 always reads 0x03 and register 8 always reads 0x02. Writes to either have no effect.
- R7: Write data beyond register 8 is acknowledged and dropped. Read data beyond register 8 is 0xFF.
- R8: A master NACK after a read byte ends the transfer. The slave releases SDA and drives nothing until a new START.
- R9: A STOP, or a repeated START, at any point abandons the current transfer. The next transfer begins again with address decoding and its own command and count bytes.
- R10: The slave begins driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_fs | input | 4 | Frequency-select straps |
| strap_sel | input | 1 | 24/48 select strap |
| cfg_flat | output | 72 | Nine register bytes as read back, register k at [8k+7:8k] |

## Verification
The hardest situations to reach from the ports are the ones that cut a transfer short: a STOP in the middle of a write, a repeated START straight after data bytes, and a master NACK followed by further clocking. In each of these, the slave must forget its byte position. The bench drives these sequences as directed cases. After each one it reads back through the bus, so that a slave which kept stale framing returns misplaced data or still drives SDA. Random writes of 0 to 11 data bytes then cover short and over-long bursts, including writes into the read-only bytes.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  localparam int NREG  = 9;
  localparam int IDX_W = 4;
  localparam logic [6:0] DEV_ADDR  = 7'h69;
  localparam logic [7:0] BLK_COUNT = 8'h09;
  localparam logic [7:0] PAST_END  = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_ACK, S_TX, S_MACK
  } slv_state_e;

  // which bits of register i accept bus writes
  function automatic logic [7:0] wr_mask(input int i);
    case (i)
      5:       return 8'h03;
      6, 8:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // reset content of the writable part
  function automatic logic [7:0] reset_byte(input int i);
    case (i)
      0:       return 8'h42;
      7:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // value of the bits that are not writable
  function automatic logic [7:0] fixed_byte(input int i, input logic [3:0] fs, input logic sel);
    case (i)
      5:       return {~fs, 1'b1, ~sel, 2'b00};
      6:       return 8'h03;
      8:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgslv_sync.sv
module cfgslv_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgslv_regfile.sv
module cfgslv_regfile
  import cfgslv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       strap_fs,
  input  logic             strap_sel,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [NREG*8-1:0] cfg_flat
);
  logic [4:0] strap_q;
  logic [7:0] view [NREG];

  // straps are held while reset is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= {strap_fs, strap_sel};
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(g);
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reset_byte(g) & MASK;
      else if (wr_en && wr_addr == IDX_W'(g))
        q <= (q & ~MASK) | (wr_data & MASK);
    end
    assign view[g] = (q & MASK) | (fixed_byte(g, strap_q[4:1], strap_q[0]) & ~MASK);
    assign cfg_flat[8*g +: 8] = view[g];
  end

  always_comb begin
    rd_byte = PAST_END;
    if (rd_idx == '0) rd_byte = BLK_COUNT;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i + 1)) rd_byte = view[i];
  end

  a_r2_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < IDX_W'(NREG)));

  a_r5_ro_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == IDX_W'(5)) |=> (view[5][7:2] == $past(view[5][7:2])));
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import cfgslv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        strap_fs,
  input  logic              strap_sel,
  output logic [NREG*8-1:0] cfg_flat
);
  localparam int WR_FIRST = 2;
  localparam int WR_LAST  = WR_FIRST + NREG;

  logic scl_lvl, sda_lvl, scl_d, sda_d;
  logic scl_rise, scl_fall, ev_start, ev_stop;
  slv_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx_sh, rd_byte;
  logic rw, go_on, oe_q;
  logic [IDX_W-1:0] wr_idx, rd_idx, wr_addr;
  logic wr_en, byte_done;

  cfgslv_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_lvl, sda_lvl}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  // bus events
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign ev_start  = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign ev_stop   = scl_lvl & scl_d & ~sda_d & sda_lvl;
  assign byte_done = scl_fall && (bitcnt == 4'd8);

  assign wr_en   = (state == S_RX) && byte_done &&
                   (wr_idx >= IDX_W'(WR_FIRST)) && (wr_idx < IDX_W'(WR_LAST));
  assign wr_addr = wr_idx - IDX_W'(WR_FIRST);

  cfgslv_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .strap_sel(strap_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(sh),
    .rd_idx(rd_idx), .rd_byte(rd_byte), .cfg_flat(cfg_flat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= '0;
      sh     <= '0;
      tx_sh  <= '0;
      rw     <= 1'b0;
      go_on  <= 1'b0;
      oe_q   <= 1'b0;
      wr_idx <= '0;
      rd_idx <= '0;
    end else if (ev_start) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      oe_q   <= 1'b0;
      go_on  <= 1'b0;
      wr_idx <= '0;
      rd_idx <= '0;
    end else if (ev_stop) begin
      state <= S_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_RX: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            if (state == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw    <= sh[0];
                oe_q  <= 1'b1;
                state <= S_ACK;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              oe_q  <= 1'b1;
              state <= S_ACK;
              if (wr_idx != '1) wr_idx <= wr_idx + 1'b1;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (!rw) begin
              oe_q  <= 1'b0;
              state <= S_RX;
            end else begin
              tx_sh <= rd_byte;
              oe_q  <= ~rd_byte[7];
              state <= S_TX;
              if (rd_idx != '1) rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            oe_q  <= 1'b0;
            go_on <= 1'b0;
            state <= S_MACK;
          end else if (scl_fall) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            oe_q  <= ~tx_sh[6];
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_lvl) state <= S_IDLE;
            else         go_on <= 1'b1;
          end else if (scl_fall && go_on) begin
            go_on  <= 1'b0;
            bitcnt <= '0;
            tx_sh  <= rd_byte;
            oe_q   <= ~rd_byte[7];
            state  <= S_TX;
            if (rd_idx != '1) rd_idx <= rd_idx + 1'b1;
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe = oe_q;

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (state == S_IDLE && !sda_oe));

  a_r1_no_ack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && byte_done && sh[7:1] != DEV_ADDR) |=> (state == S_IDLE && !sda_oe));

  a_r8_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && scl_rise && sda_lvl && !ev_start && !ev_stop) |=> (state == S_IDLE));
endmodule

// File: tb/clkgen_cfg_slave_tb_top.sv
module clkgen_cfg_slave_tb_top;
  localparam int Q = 10;
  localparam int NR = 9;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [3:0] fs = 4'b1010;
  logic sel = 1'b1;
  logic [NR*8-1:0] cfg_flat;
  wire sda_line = sda_m & ~sda_oe;

  int n_cmp = 0, n_bad = 0, r10_viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] mdl [NR];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;

  clkgen_cfg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_fs(fs), .strap_sel(sel), .cfg_flat(cfg_flat));

  // R10 monitor: a new low drive must start while the wire clock is low
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic logic [7:0] exp_view(input int i);
    case (i)
      5:       return {~fs, 1'b1, ~sel, mdl[5][1:0]};
      6:       return 8'h03;
      8:       return 8'h02;
      default: return mdl[i];
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input int k);
    if (k == 0) return 8'h09;
    if (k <= NR) return exp_view(k - 1);
    return 8'hFF;
  endfunction

  task automatic mdl_write(input int i, input logic [7:0] d);
    if (i == 5) mdl[5][1:0] = d[1:0];
    else if (i < NR && i != 6 && i != 8) mdl[i] = d;
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    sda_m = v; hold(Q);
    scl = 1'b1; hold(Q / 2);
    s = sda_line; hold(Q / 2);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(Q);
    scl = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~ack, s);
  endtask

  // write transfer: address, command, count, then n data bytes
  task automatic do_write(input int n, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a); check({tag, " R1 addr ack"}, {7'd0, a}, 8'd1);
    send_byte(8'h5A, a); check({tag, " R2 cmd ack"}, {7'd0, a}, 8'd1);
    send_byte(8'h07, a); check({tag, " R2 count ack"}, {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      check({tag, (k >= NR) ? " R7 extra ack" : " R2 data ack"}, {7'd0, a}, 8'd1);
      mdl_write(k, wbuf[k]);
    end
    bus_stop();
  endtask

  task automatic do_read(input int n);
    logic a;
    bus_start();
    send_byte(8'hD3, a); check("R1 read addr ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic check_readback(input string tag);
    do_read(NR + 2);
    check({tag, " R3 count"}, rbuf[0], 8'h09);
    for (int k = 1; k <= NR; k++) check({tag, " R3 reg"}, rbuf[k], exp_read(k));
    check({tag, " R7 past end"}, rbuf[NR + 1], 8'hFF);
    for (int i = 0; i < NR; i++) check({tag, " R2 parallel"}, cfg_flat[8*i +: 8], exp_view(i));
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'h00C0FFEE));
    mdl[0] = 8'h42; mdl[1] = 8'hFF; mdl[2] = 8'hFF; mdl[3] = 8'hFF; mdl[4] = 8'hFF;
    mdl[5] = 8'h03; mdl[6] = 8'h00; mdl[7] = 8'h00; mdl[8] = 8'h00;
    hold(5);
    rst_n = 1'b1;
    hold(5);

    // R4 / R5 / R6: reset state on the parallel outputs
    check("R4 reg0", cfg_flat[7:0], 8'h42);
    for (int i = 1; i <= 4; i++) check("R4 reg1-4", cfg_flat[8*i +: 8], 8'hFF);
    check("R5 reg5 straps", cfg_flat[47:40], 8'h5B);
    check("R6 reg6", cfg_flat[55:48], 8'h03);
    check("R4 reg7", cfg_flat[63:56], 8'h00);
    check("R6 reg8", cfg_flat[71:64], 8'h02);
    check_readback("reset");

    // R1: foreign address is ignored together with its data
    bus_start();
    send_byte(8'hA4, a); check("R1 foreign nack", {7'd0, a}, 8'd0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h99, a);
    bus_stop();
    check("R1 ignored data", cfg_flat[7:0], 8'h42);
    bus_start();
    send_byte(8'hD0, a); check("R1 near-miss nack", {7'd0, a}, 8'd0);
    bus_stop();

    // R2 / R5 / R6 / R7: long write touching read-only bytes and past the end
    for (int k = 0; k < 11; k++) wbuf[k] = 8'h10 + 8'(k * 17);
    wbuf[5] = 8'h00; wbuf[6] = 8'hAA; wbuf[8] = 8'hFF;
    do_write(11, "long");
    check("R5 ro bits kept", cfg_flat[47:40], {~fs, 1'b1, ~sel, 2'b00});
    check("R6 reg6 kept", cfg_flat[55:48], 8'h03);
    check("R6 reg8 kept", cfg_flat[71:64], 8'h02);
    check_readback("long");

    // R9: STOP mid write, new transfer restarts framing
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h11, a); mdl_write(0, 8'h11);
    bus_stop();
    wbuf[0] = 8'h22;
    do_write(1, "restart");
    check("R9 stop restart reg0", cfg_flat[7:0], 8'h22);
    check("R9 stop restart reg1", cfg_flat[15:8], mdl[1]);

    // R9: repeated START straight into a read
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h33, a); mdl_write(0, 8'h33);
    send_byte(8'h44, a); mdl_write(1, 8'h44);
    bus_start();
    send_byte(8'hD3, a); check("R9 rs addr ack", {7'd0, a}, 8'd1);
    recv_byte(1'b1, b); check("R9 rs count", b, 8'h09);
    recv_byte(1'b1, b); check("R9 rs reg0", b, 8'h33);
    recv_byte(1'b0, b); check("R9 rs reg1", b, 8'h44);
    bus_stop();

    // R8: NACK ends the read; further clocks see a released line
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, b); check("R8 count before nack", b, 8'h09);
    recv_byte(1'b0, b); check("R8 released after nack", b, 8'hFF);
    bus_stop();
    do_read(2);
    check("R8 next read count", rbuf[0], 8'h09);
    check("R8 next read reg0", rbuf[1], exp_read(1));

    // random bursts, R2 / R3 / R7
    for (int it = 0; it < 6; it++) begin
      int n;
      n = $urandom_range(0, 11);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(n, "rand");
      check_readback("rand");
    end

    check("R10 drive only while scl low", 8'(r10_viol), 8'd0);
    finish_run();
  end
endmodule